// File: doc/BRIEF.md
# Kick-Monitoring Watchdog with Shutdown Escalation

This block supervises a processor through a single kick line. The kick line is asynchronous to the block clock. Every rising or falling transition on it counts as proof of life. If the line sits at one level for a full programmed interval, the block drives a reset pulse of programmed width. It keeps pulsing, one interval apart, until a kick transition is seen again.

A mode input chooses between two policies. In the plain policy the block only pulses reset. In the escalating policy it counts reset pulses that went unanswered. When the fourth consecutive unanswered pulse starts, a shutdown output rises in the same cycle. Shutdown stays high for a programmed number of cycles and then drops. After that the count begins afresh, and the cycle repeats for as long as the kick line stays silent.

The interval, the pulse width and the shutdown length are all inputs counted in clock cycles. A long shutdown, such as one second, is therefore just a large count.

Top module: `wdog_escalate`

## Requirements
- R1: While the synchronous reset `rst` is high, `wd_rst_o` and `shdn_o` are low, and the interval count starts from zero when reset is released.
- R2: A rising transition and a falling transition on `kick_i` are both valid activity. The transition passes a two-flop synchronizer plus one edge-detect flop, so a transition applied after clock edge c restarts the interval as if it had just begun at edge c+3.
- R3: Once an interval begins at edge n, with no kick transition, `wd_rst_o` rises right after edge n+T, where T is `timeout_cyc_i`.
- R4: Each reset pulse lasts exactly P cycles, where P is `pulse_cyc_i`. The next interval begins only when the pulse ends, so unanswered pulses repeat with period T+P.
- R5: With `adv_mode_i` low, `shdn_o` never rises.
- R6: With `adv_mode_i` high, three unanswered pulses pass first. `shdn_o` then rises in the same cycle as the fourth unanswered pulse.
- R7: `shdn_o` stays high for exactly S cycles, where S is `shdn_cyc_i`. The next interval begins once both the pulse and the shutdown have ended. The count restarts from zero, so the next shutdown comes with the fourth pulse after that.
- R8: A kick transition seen during a reset pulse leaves that pulse's width and the following interval unchanged. It does clear the unanswered-pulse count, which delays the next shutdown.
- R9: A kick transition seen while `shdn_o` is high does not shorten the shutdown, and does not move the following pulses.
- R10: A programmed value of zero for T, P or S acts as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_i | input | 1 | Asynchronous proof-of-life line; either edge services the watchdog |
| adv_mode_i | input | 1 | 1 = escalate to shutdown, 0 = reset pulses only |
| timeout_cyc_i | input | TW | Interval length T in cycles |
| pulse_cyc_i | input | TW | Reset pulse width P in cycles |
| shdn_cyc_i | input | SW | Shutdown length S in cycles |
| wd_rst_o | output | 1 | Watchdog reset pulse, active high |
| shdn_o | output | 1 | Shutdown request, active high |

## Verification
A silent kick line in plain mode shows the steady pulse train and its period. The same silence in escalating mode shows the three-then-shutdown pattern, once with a shutdown longer than the pulse and once with a shutdown shorter than it. A rising kick and a falling kick in one run show that both edge polarities restart the interval by the same amount. A kick placed inside a pulse shifts the shutdown by a full round while leaving the pulse timing alone. A kick placed inside a shutdown shows that the shutdown is not cut short. A run with a zero pulse width shows the one-cycle floor.

// File: rtl/wde_pkg.sv
package wde_pkg;

    // Phase of the supervisor: counting an interval, driving a reset
    // pulse, or waiting for a shutdown to finish after its pulse ended.
    typedef enum logic [1:0] {
        PH_WATCH = 2'd0,
        PH_PULSE = 2'd1,
        PH_HOLD  = 2'd2
    } wde_phase_e;

    // Control bundle handed from the sequencer to the interval counter.
    typedef struct packed {
        logic en;
        logic clr;
        logic use_pulse_len;
    } wde_cnt_ctl_s;

    // A programmed length of zero is taken as a single cycle.
    function automatic logic [31:0] at_least_one(input logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction

endpackage

// File: rtl/wde_kick_sync.sv
module wde_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_i,
    output logic kick_edge_o
);
    // stage 0..STAGES-1 synchronize, stage STAGES holds the previous level
    logic [STAGES:0] sr_q;

    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sr_q[0] <= 1'b0;
                else     sr_q[0] <= kick_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sr_q[g] <= 1'b0;
                else     sr_q[g] <= sr_q[g-1];
            end
        end
    end

    assign kick_edge_o = sr_q[STAGES] ^ sr_q[STAGES-1];

endmodule

// File: rtl/wde_interval.sv
module wde_interval #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // limit is at least one; done marks the last counted cycle
    assign done = en && (cnt_q == limit - W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (en)    cnt_q <= done ? '0 : cnt_q + W'(1);
    end

endmodule

// File: rtl/wde_ctrl.sv
module wde_ctrl
    import wde_pkg::*;
#(
    parameter int ESC_PULSES = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv_i,
    input  logic         kick_edge_i,
    input  logic         phase_done_i,
    input  logic         shdn_done_i,
    output wde_phase_e   phase_o,
    output wde_cnt_ctl_s cnt_ctl_o,
    output logic         shdn_o
);
    localparam int FW = (ESC_PULSES > 2) ? $clog2(ESC_PULSES) : 1;
    localparam logic [FW-1:0] LAST_FAIL = FW'(ESC_PULSES - 1);

    wde_phase_e    ph_q;
    logic          shdn_q;
    logic [FW-1:0] fails_q;
    logic          watch_expire;
    logic          escalate;

    assign watch_expire = (ph_q == PH_WATCH) && phase_done_i;
    assign escalate     = watch_expire && adv_i && (fails_q == LAST_FAIL);

    always_comb begin
        cnt_ctl_o.en            = (ph_q == PH_PULSE) ||
                                  ((ph_q == PH_WATCH) && !kick_edge_i);
        cnt_ctl_o.clr           = (ph_q == PH_HOLD) ||
                                  ((ph_q == PH_WATCH) && kick_edge_i);
        cnt_ctl_o.use_pulse_len = (ph_q == PH_PULSE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_WATCH;
        end else begin
            unique case (ph_q)
                PH_WATCH: if (phase_done_i) ph_q <= PH_PULSE;
                PH_PULSE: if (phase_done_i)
                              ph_q <= (shdn_q && !shdn_done_i) ? PH_HOLD : PH_WATCH;
                PH_HOLD:  if (shdn_done_i) ph_q <= PH_WATCH;
                default:  ph_q <= PH_WATCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              shdn_q <= 1'b0;
        else if (escalate)    shdn_q <= 1'b1;
        else if (shdn_done_i) shdn_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)               fails_q <= '0;
        else if (kick_edge_i)  fails_q <= '0;
        else if (watch_expire) fails_q <= (!adv_i || escalate) ? '0 : fails_q + FW'(1);
    end

    assign phase_o = ph_q;
    assign shdn_o  = shdn_q;

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
    import wde_pkg::*;
#(
    parameter int TW          = 16,
    parameter int SW          = 27,
    parameter int SYNC_STAGES = 2,
    parameter int ESC_PULSES  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kick_i,
    input  logic          adv_mode_i,
    input  logic [TW-1:0] timeout_cyc_i,
    input  logic [TW-1:0] pulse_cyc_i,
    input  logic [SW-1:0] shdn_cyc_i,
    output logic          wd_rst_o,
    output logic          shdn_o
);
    logic          kick_edge;
    logic          phase_done;
    logic          shdn_done;
    logic          shdn_on;
    wde_phase_e    phase;
    wde_cnt_ctl_s  cnt_ctl;
    logic [TW-1:0] eff_timeout;
    logic [TW-1:0] eff_pulse;
    logic [SW-1:0] eff_shdn;
    logic [TW-1:0] phase_limit;

    assign eff_timeout = TW'(at_least_one(32'(timeout_cyc_i)));
    assign eff_pulse   = TW'(at_least_one(32'(pulse_cyc_i)));
    assign eff_shdn    = SW'(at_least_one(32'(shdn_cyc_i)));
    assign phase_limit = cnt_ctl.use_pulse_len ? eff_pulse : eff_timeout;

    wde_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .kick_i      (kick_i),
        .kick_edge_o (kick_edge)
    );

    wde_interval #(.W(TW)) u_phase_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_ctl.clr),
        .en    (cnt_ctl.en),
        .limit (phase_limit),
        .done  (phase_done)
    );

    wde_interval #(.W(SW)) u_shdn_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (!shdn_on),
        .en    (shdn_on),
        .limit (eff_shdn),
        .done  (shdn_done)
    );

    wde_ctrl #(.ESC_PULSES(ESC_PULSES)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .adv_i        (adv_mode_i),
        .kick_edge_i  (kick_edge),
        .phase_done_i (phase_done),
        .shdn_done_i  (shdn_done),
        .phase_o      (phase),
        .cnt_ctl_o    (cnt_ctl),
        .shdn_o       (shdn_on)
    );

    assign wd_rst_o = (phase == PH_PULSE);
    assign shdn_o   = shdn_on;

endmodule

// File: rtl/wdog_escalate_chk.sv
module wdog_escalate_chk #(
    parameter int TW = 16,
    parameter int SW = 27
) (
    input logic          clk,
    input logic          rst,
    input logic          adv_mode_i,
    input logic [TW-1:0] pulse_cyc_i,
    input logic [SW-1:0] shdn_cyc_i,
    input logic          wd_rst_o,
    input logic          shdn_o
);
    logic [31:0] pulse_run_q;
    logic [31:0] shdn_run_q;
    logic [31:0] want_pulse;
    logic [31:0] want_shdn;

    assign want_pulse = (pulse_cyc_i == '0) ? 32'd1 : 32'(pulse_cyc_i);
    assign want_shdn  = (shdn_cyc_i == '0)  ? 32'd1 : 32'(shdn_cyc_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_run_q <= '0;
            shdn_run_q  <= '0;
        end else begin
            pulse_run_q <= wd_rst_o ? pulse_run_q + 32'd1 : 32'd0;
            shdn_run_q  <= shdn_o   ? shdn_run_q + 32'd1  : 32'd0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!wd_rst_o && !shdn_o));

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_rst_o) |-> (pulse_run_q == want_pulse));

    // R5
    plain_no_shdn_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv_mode_i && !shdn_o) |=> !shdn_o);

    // R6
    shdn_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(shdn_o) |-> $rose(wd_rst_o));

    // R7
    shdn_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(shdn_o) |-> (shdn_run_q == want_shdn));

endmodule

bind wdog_escalate wdog_escalate_chk #(.TW(TW), .SW(SW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .adv_mode_i  (adv_mode_i),
    .pulse_cyc_i (pulse_cyc_i),
    .shdn_cyc_i  (shdn_cyc_i),
    .wd_rst_o    (wd_rst_o),
    .shdn_o      (shdn_o)
);

// File: tb/wdog_escalate_test.sv
module wdog_escalate_test;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 16;
    localparam int SW = 27;

    typedef struct {
        int    cyc;
        int    kind;   // 0 rst rise, 1 rst fall, 2 shdn rise, 3 shdn fall
        string tag;
    } ev_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          kick = 1'b0;
    logic          adv = 1'b0;
    logic [TW-1:0] t_cfg = TW'(10);
    logic [TW-1:0] p_cfg = TW'(3);
    logic [SW-1:0] s_cfg = SW'(20);
    logic          wd_rst_o;
    logic          shdn_o;

    int  cyc = 0;
    int  checks = 0;
    int  errors = 0;
    int  eT, eP, eS;
    bit  prev_r = 1'b0;
    bit  prev_s = 1'b0;
    ev_t expq[$];

    wdog_escalate #(.TW(TW), .SW(SW)) uut (
        .clk           (clk),
        .rst           (rst),
        .kick_i        (kick),
        .adv_mode_i    (adv),
        .timeout_cyc_i (t_cfg),
        .pulse_cyc_i   (p_cfg),
        .shdn_cyc_i    (s_cfg),
        .wd_rst_o      (wd_rst_o),
        .shdn_o        (shdn_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic consume(input int kind);
        ev_t e;
        checks++;
        if (expq.size() == 0) begin
            errors++;
            $display("FAIL unexpected event: kind %0d at cycle %0d, expected none", kind, cyc);
        end else begin
            e = expq.pop_front();
            if (e.kind != kind || e.cyc != cyc) begin
                errors++;
                $display("FAIL %s: kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                         e.tag, kind, cyc, e.kind, e.cyc);
            end
        end
    endtask

    // monitor: pops expected events as output transitions appear
    always @(negedge clk) begin
        if (!rst) begin
            if (wd_rst_o && !prev_r)  consume(0);
            if (!wd_rst_o && prev_r)  consume(1);
            if (shdn_o && !prev_s)    consume(2);
            if (!shdn_o && prev_s)    consume(3);
        end
        prev_r = wd_rst_o;
        prev_s = shdn_o;
    end

    task automatic push(input int c, input int k, input int lo, input int hi, input string tag);
        ev_t e;
        if (c >= lo && c <= hi) begin
            e.cyc = c; e.kind = k; e.tag = tag;
            expq.push_back(e);
        end
    endtask

    // expected timeline from the requirements, for an interval starting at `start`
    task automatic plan(input int start, input int f0, input int lo, input int hi,
                        input bit esc_mode, input string tag);
        int t = start;
        int f = f0;
        int r;
        bit esc;
        while (1) begin
            r = t + eT;
            if (r > hi) break;
            esc = esc_mode && (f == 3);
            push(r, 0, lo, hi, tag);
            if (esc) begin
                push(r, 2, lo, hi, tag);
                if (eP <= eS) begin
                    push(r + eP, 1, lo, hi, tag);
                    push(r + eS, 3, lo, hi, tag);
                end else begin
                    push(r + eS, 3, lo, hi, tag);
                    push(r + eP, 1, lo, hi, tag);
                end
                f = 0;
                t = r + ((eP > eS) ? eP : eS);
            end else begin
                push(r + eP, 1, lo, hi, tag);
                f = esc_mode ? f + 1 : 0;
                t = r + eP;
            end
        end
    endtask

    task automatic begin_run(input bit m, input int t, input int p, input int s);
        rst = 1'b1;
        kick = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (wd_rst_o !== 1'b0 || shdn_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: outputs in reset rst=%b shdn=%b, expected 0 0", wd_rst_o, shdn_o);
        end
        adv = m;
        t_cfg = TW'(t); p_cfg = TW'(p); s_cfg = SW'(s);
        eT = (t == 0) ? 1 : t;
        eP = (p == 0) ? 1 : p;
        eS = (s == 0) ? 1 : s;
    endtask

    task automatic go();
        rst = 1'b0;
    endtask

    task automatic wait_cyc(input int c);
        while (cyc != c) @(negedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic end_run(input int h, input string tag);
        wait_cyc(h);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d expected events missing, first at cycle %0d, expected 0 missing",
                     tag, expq.size(), expq[0].cyc);
            expq.delete();
        end
        rst = 1'b1;
    endtask

    initial begin
        // plain mode, silent kick line: R3 first pulse, R4 width and period, R5 no shutdown
        begin_run(1'b0, 10, 3, 20);
        plan(0, 0, 0, 70, 1'b0, "R3,R4,R5");
        go();
        end_run(70, "R3,R4,R5");

        // R2: rising kick at 30, falling kick at 50
        begin_run(1'b0, 10, 3, 20);
        plan(0, 0, 0, 30, 1'b0, "R2");
        plan(33, 0, 31, 50, 1'b0, "R2");
        plan(53, 0, 51, 100, 1'b0, "R2");
        go();
        wait_cyc(30); kick = 1'b1;
        wait_cyc(50); kick = 1'b0;
        end_run(100, "R2");

        // R6, R7: escalation with shutdown longer than the pulse, two rounds
        begin_run(1'b1, 8, 2, 20);
        plan(0, 0, 0, 130, 1'b1, "R6,R7");
        go();
        end_run(130, "R6,R7");

        // R7: shutdown shorter than the pulse
        begin_run(1'b1, 6, 5, 2);
        plan(0, 0, 0, 100, 1'b1, "R7");
        go();
        end_run(100, "R7");

        // R8: kick inside the second pulse clears the failed count only
        begin_run(1'b1, 8, 6, 4);
        plan(0, 0, 0, 28, 1'b1, "R8");
        plan(28, 0, 29, 140, 1'b1, "R8");
        go();
        wait_cyc(23); kick = 1'b1;
        end_run(140, "R8");

        // R9: kick during the shutdown changes nothing
        begin_run(1'b1, 8, 2, 20);
        plan(0, 0, 0, 130, 1'b1, "R9");
        go();
        wait_cyc(45); kick = 1'b1;
        end_run(130, "R9");

        // R10: zero pulse width acts as one cycle
        begin_run(1'b0, 5, 0, 20);
        plan(0, 0, 0, 40, 1'b0, "R10");
        go();
        end_run(40, "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run still active at cycle %0d, expected finished", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule